// File: doc/BRIEF.md
# Low-Address Protection and Prefix Unit

This block sits beside an address-translation walker and handles the checks and the mapping around it. For every access it decides whether the address lies in one of the two protected low windows and whether that protection is currently active. It then raises a protection fault for a store into a protected window, passes on a fault reported by the walker, and raises protection faults for stores through a read-only translation and for fetches through a no-execute translation. For each access it also builds the exception code word that the fault handler reads.

When no fault is raised, the block forms the real address. This is the page-aligned logical address when translation is off, or the page-aligned address returned by the walker when translation is on. The block then converts the real address into an absolute address through the prefix register, which swaps the low-storage area with the area the prefix selects. It accepts one request per cycle. All results are registered and come out one cycle later, qualified by a one-cycle valid pulse.

Top module: `lap_prefix_unit`

## Requirements
- R1: After reset all outputs are zero. Each cycle with `req_valid` high produces exactly one cycle of `out_valid` on the following clock edge, with the results of that request. A cycle without a request leaves `out_valid` low on the next edge.
- R2: A protected byte lies in 0..511 or in 4096..4607. A store (access code 1) to a protected byte while protection is active gives `out_fault`=1, `out_code`=0x04, bit 0x80 set in `out_tec`, and `out_abs`=0. A store to any other byte raises no fault from this rule.
- R3: Protection is active only when `lap_enable` is 1. With `dat_enable`=0 it applies in every space. With `dat_enable`=1 it applies only when the private bit of the selected space is 0. Space codes on `req_asc`: 0 primary (private bit 0), 2 secondary (private bit 1), 3 home (private bit 2), 1 access-register.
- R4: Access-register space (code 1) with `dat_enable`=1 sets `out_mode_err`. In that case `out_fault`, `out_wr_inv` and `out_abs` are all 0 and no protection rule is applied.
- R5: The base of `out_tec` is the page-aligned address (4 KiB pages), ORed with the space code in bits 1:0. It also carries 0x400 for a store, or 0x800 for a load (code 0), a fetch (code 2) or code 3.
- R6: `out_wr_inv` is 1 whenever protection is active and the page of the access starts inside a protected window, which means the address is below 0x2000. This holds for every access type and also when a fault is reported.
- R7: With `dat_enable`=1, a walker fault gives `out_fault`=1, `out_code`=`walk_code`, the base code word with no extra bits, and `out_abs`=0.
- R8: With `dat_enable`=1, a store whose translation has `walk_write_ok`=0 faults with code 0x04 and ORs 0x4 into `out_tec`.
- R9: With `dat_enable`=1, a fetch whose translation has `walk_exec_ok`=0 faults with code 0x04 and ORs 0x84 into `out_tec`.
- R10: Only one fault is reported per access, chosen in this priority order: low-address protection, then the walker fault, then write protection, then execute protection. Loads ignore both permission inputs.
- R11: Prefixing uses wide, non-wrapping comparisons. A real address below 0x2000 maps to the real address plus the prefix. Otherwise, a real address at or above the prefix and below the prefix plus 0x2000 maps to the real address minus the prefix. Any other address is unchanged. Sums and differences wrap at the address width.
- R12: The real address is the page-aligned `req_addr` when `dat_enable`=0 and the page-aligned `walk_real` when `dat_enable`=1. Without translation the walker inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Logical or real address of the access |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| req_asc | input | 2 | Address-space code |
| lap_enable | input | 1 | Low-address protection enable |
| dat_enable | input | 1 | Translation enabled |
| asce_private | input | 3 | Private-space bits: primary, secondary, home |
| walk_fault | input | 1 | Walker reported a translation fault |
| walk_code | input | CODE_W | Walker fault code |
| walk_write_ok | input | 1 | Translation permits stores |
| walk_exec_ok | input | 1 | Translation permits fetches |
| walk_real | input | ADDR_W | Real address from the walker |
| prefix | input | ADDR_W | Prefix register value |
| out_valid | output | 1 | Result valid pulse |
| out_abs | output | ADDR_W | Absolute address, zero on fault |
| out_fault | output | 1 | Fault raised |
| out_code | output | CODE_W | Fault code |
| out_tec | output | ADDR_W | Exception code word |
| out_wr_inv | output | 1 | Cached translation must not serve writes |
| out_mode_err | output | 1 | Unsupported access-register space |

## Verification
The bench builds the unit with a 16-bit address, 4 KiB pages, 512-byte windows, two windows and an 8-bit code. With that address width, a store can be applied to every byte of the two low pages, so both window edges (511/512 and 4607/4608) and the page test are covered completely. The prefix can be stepped across its whole range against all sixteen pages, which places every mapping boundary, and wrap-around of the sum and difference, inside the sweep. The remaining inputs are small enough to enumerate: every space, private-bit, enable and permission combination is crossed with the window-edge addresses.

// File: rtl/lap_pkg.sv
package lap_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      SPC_PRIMARY   = 2'd0,
      SPC_ACCREG    = 2'd1,
      SPC_SECONDARY = 2'd2,
      SPC_HOME      = 2'd3
   } spc_e;

   // Bit positions inside the exception code word
   localparam int unsigned TEC_RD_BIT    = 11;
   localparam int unsigned TEC_WR_BIT    = 10;
   localparam int unsigned TEC_LAP_BIT   = 7;
   localparam int unsigned TEC_DAT_BIT   = 2;
   localparam int unsigned TEC_SPACE_MSB = 1;

   // Private-bit slot per space inside asce_private
   localparam int unsigned PRIV_PRIMARY   = 0;
   localparam int unsigned PRIV_SECONDARY = 1;
   localparam int unsigned PRIV_HOME      = 2;

endpackage

// File: rtl/lap_window_check.sv
module lap_window_check #(
   parameter int ADDR_W      = 64,
   parameter int PAGE_BITS   = 12,
   parameter int LAP_BYTES   = 512,
   parameter int NUM_WINDOWS = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              byte_hit,
   output logic              page_hit
);
   localparam int PN_W = ADDR_W - PAGE_BITS;

   logic [PN_W-1:0]        pnum;
   logic [PAGE_BITS-1:0]   offs;
   logic [NUM_WINDOWS-1:0] pg_hit;
   logic [NUM_WINDOWS-1:0] by_hit;

   assign pnum = addr[ADDR_W-1:PAGE_BITS];
   assign offs = addr[PAGE_BITS-1:0];

   // Window k starts at the base of page k and spans LAP_BYTES bytes
   for (genvar k = 0; k < NUM_WINDOWS; k++) begin : g_win
      assign pg_hit[k] = (pnum == PN_W'(k));
      assign by_hit[k] = pg_hit[k] && (offs < PAGE_BITS'(LAP_BYTES));
   end

   assign page_hit = |pg_hit;
   assign byte_hit = |by_hit;

endmodule

// File: rtl/lap_space_select.sv
module lap_space_select (
   input  logic       lap_enable,
   input  logic       dat_enable,
   input  logic [1:0] asc,
   input  logic [2:0] asce_private,
   output logic       lap_active,
   output logic       mode_err
);
   import lap_pkg::*;

   logic priv_sel;

   always_comb begin
      priv_sel = 1'b0;
      case (spc_e'(asc))
         SPC_PRIMARY:   priv_sel = asce_private[PRIV_PRIMARY];
         SPC_SECONDARY: priv_sel = asce_private[PRIV_SECONDARY];
         SPC_HOME:      priv_sel = asce_private[PRIV_HOME];
         default:       priv_sel = 1'b0;
      endcase
   end

   assign mode_err   = dat_enable && (spc_e'(asc) == SPC_ACCREG);
   assign lap_active = lap_enable && !mode_err && (!dat_enable || !priv_sel);

endmodule

// File: rtl/lap_prefix_map.sv
module lap_prefix_map #(
   parameter int ADDR_W      = 64,
   parameter int PREFIX_SPAN = 32'h2000,
   parameter bit PREFIX_EN   = 1'b1
) (
   input  logic [ADDR_W-1:0] real_addr,
   input  logic [ADDR_W-1:0] prefix,
   output logic [ADDR_W-1:0] abs_addr
);
   if (PREFIX_EN) begin : g_map
      localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(PREFIX_SPAN);

      logic [ADDR_W:0] r_ext;
      logic [ADDR_W:0] p_ext;
      logic [ADDR_W:0] p_end;
      logic            in_low;
      logic            in_pfx;

      // One extra bit keeps the prefix window end from wrapping
      assign r_ext  = {1'b0, real_addr};
      assign p_ext  = {1'b0, prefix};
      assign p_end  = p_ext + SPAN;
      assign in_low = r_ext < SPAN;
      assign in_pfx = (r_ext >= p_ext) && (r_ext < p_end);

      always_comb begin
         if (in_low)
            abs_addr = real_addr + prefix;
         else if (in_pfx)
            abs_addr = real_addr - prefix;
         else
            abs_addr = real_addr;
      end
   end else begin : g_pass
      assign abs_addr = real_addr;
   end

endmodule

// File: rtl/lap_fault_arbiter.sv
module lap_fault_arbiter #(
   parameter int ADDR_W    = 64,
   parameter int PAGE_BITS = 12,
   parameter int CODE_W    = 8,
   parameter int PROT_CODE = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        acc,
   input  logic [1:0]        asc,
   input  logic              dat_enable,
   input  logic              lap_active,
   input  logic              mode_err,
   input  logic              byte_hit,
   input  logic              page_hit,
   input  logic              walk_fault,
   input  logic [CODE_W-1:0] walk_code,
   input  logic              walk_write_ok,
   input  logic              walk_exec_ok,
   input  logic [ADDR_W-1:0] mapped_abs,
   output logic              fault,
   output logic [CODE_W-1:0] code,
   output logic [ADDR_W-1:0] tec,
   output logic              wr_inv,
   output logic [ADDR_W-1:0] abs_addr
);
   import lap_pkg::*;

   logic              is_store;
   logic              is_fetch;
   logic [ADDR_W-1:0] tec_base;

   assign is_store = (acc_e'(acc) == ACC_STORE);
   assign is_fetch = (acc_e'(acc) == ACC_FETCH);

   always_comb begin
      tec_base = '0;
      tec_base[ADDR_W-1:PAGE_BITS]  = addr[ADDR_W-1:PAGE_BITS];
      tec_base[TEC_SPACE_MSB:0]     = asc;
      if (is_store) tec_base[TEC_WR_BIT] = 1'b1;
      else          tec_base[TEC_RD_BIT] = 1'b1;
   end

   // Fixed priority: window store, walker fault, write, execute
   always_comb begin
      tec      = tec_base;
      fault    = 1'b0;
      code     = '0;
      wr_inv   = lap_active && page_hit;
      abs_addr = mapped_abs;
      if (mode_err) begin
         wr_inv   = 1'b0;
         abs_addr = '0;
      end else if (lap_active && byte_hit && is_store) begin
         fault            = 1'b1;
         code             = CODE_W'(PROT_CODE);
         tec[TEC_LAP_BIT] = 1'b1;
         abs_addr         = '0;
      end else if (dat_enable && walk_fault) begin
         fault    = 1'b1;
         code     = walk_code;
         abs_addr = '0;
      end else if (dat_enable && is_store && !walk_write_ok) begin
         fault            = 1'b1;
         code             = CODE_W'(PROT_CODE);
         tec[TEC_DAT_BIT] = 1'b1;
         abs_addr         = '0;
      end else if (dat_enable && is_fetch && !walk_exec_ok) begin
         fault            = 1'b1;
         code             = CODE_W'(PROT_CODE);
         tec[TEC_LAP_BIT] = 1'b1;
         tec[TEC_DAT_BIT] = 1'b1;
         abs_addr         = '0;
      end
   end

endmodule

// File: rtl/lap_prefix_unit.sv
module lap_prefix_unit #(
   parameter int ADDR_W      = 64,
   parameter int PAGE_BITS   = 12,
   parameter int LAP_BYTES   = 512,
   parameter int NUM_WINDOWS = 2,
   parameter int CODE_W      = 8,
   parameter int PROT_CODE   = 4,
   parameter int PREFIX_SPAN = 32'h2000,
   parameter bit PREFIX_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_acc,
   input  logic [1:0]        req_asc,
   input  logic              lap_enable,
   input  logic              dat_enable,
   input  logic [2:0]        asce_private,
   input  logic              walk_fault,
   input  logic [CODE_W-1:0] walk_code,
   input  logic              walk_write_ok,
   input  logic              walk_exec_ok,
   input  logic [ADDR_W-1:0] walk_real,
   input  logic [ADDR_W-1:0] prefix,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_abs,
   output logic              out_fault,
   output logic [CODE_W-1:0] out_code,
   output logic [ADDR_W-1:0] out_tec,
   output logic              out_wr_inv,
   output logic              out_mode_err
);
   // Elaboration-time parameter checks
   if (PAGE_BITS < 12)
      $error("PAGE_BITS must leave room for the code-word flag bits");
   if (ADDR_W <= PAGE_BITS + 1)
      $error("ADDR_W too small for PAGE_BITS");
   if (LAP_BYTES < 1 || LAP_BYTES >= (1 << PAGE_BITS))
      $error("LAP_BYTES must be inside one page");
   if (NUM_WINDOWS < 1)
      $error("NUM_WINDOWS must be at least 1");
   if (CODE_W < 3 || PROT_CODE >= (1 << CODE_W))
      $error("CODE_W cannot hold PROT_CODE");

   logic              byte_hit;
   logic              page_hit;
   logic              lap_active;
   logic              mode_err;
   logic [ADDR_W-1:0] real_sel;
   logic [ADDR_W-1:0] real_page;
   logic [ADDR_W-1:0] mapped_abs;
   logic              c_fault;
   logic [CODE_W-1:0] c_code;
   logic [ADDR_W-1:0] c_tec;
   logic              c_wr_inv;
   logic [ADDR_W-1:0] c_abs;

   lap_window_check #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
      .LAP_BYTES(LAP_BYTES), .NUM_WINDOWS(NUM_WINDOWS)
   ) u_win (
      .addr(req_addr), .byte_hit(byte_hit), .page_hit(page_hit)
   );

   lap_space_select u_spc (
      .lap_enable(lap_enable), .dat_enable(dat_enable), .asc(req_asc),
      .asce_private(asce_private), .lap_active(lap_active), .mode_err(mode_err)
   );

   assign real_sel  = dat_enable ? walk_real : req_addr;
   assign real_page = {real_sel[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};

   lap_prefix_map #(
      .ADDR_W(ADDR_W), .PREFIX_SPAN(PREFIX_SPAN), .PREFIX_EN(PREFIX_EN)
   ) u_map (
      .real_addr(real_page), .prefix(prefix), .abs_addr(mapped_abs)
   );

   lap_fault_arbiter #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
      .CODE_W(CODE_W), .PROT_CODE(PROT_CODE)
   ) u_arb (
      .addr(req_addr), .acc(req_acc), .asc(req_asc),
      .dat_enable(dat_enable), .lap_active(lap_active), .mode_err(mode_err),
      .byte_hit(byte_hit), .page_hit(page_hit),
      .walk_fault(walk_fault), .walk_code(walk_code),
      .walk_write_ok(walk_write_ok), .walk_exec_ok(walk_exec_ok),
      .mapped_abs(mapped_abs),
      .fault(c_fault), .code(c_code), .tec(c_tec),
      .wr_inv(c_wr_inv), .abs_addr(c_abs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_abs      <= '0;
         out_fault    <= 1'b0;
         out_code     <= '0;
         out_tec      <= '0;
         out_wr_inv   <= 1'b0;
         out_mode_err <= 1'b0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_abs      <= c_abs;
            out_fault    <= c_fault;
            out_code     <= c_code;
            out_tec      <= c_tec;
            out_wr_inv   <= c_wr_inv;
            out_mode_err <= mode_err;
         end
      end
   end

endmodule

// File: rtl/lap_prefix_unit_chk.sv
module lap_prefix_unit_chk #(
   parameter int ADDR_W      = 64,
   parameter int PAGE_BITS   = 12,
   parameter int LAP_BYTES   = 512,
   parameter int NUM_WINDOWS = 2,
   parameter int CODE_W      = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_acc,
   input logic              lap_enable,
   input logic              dat_enable,
   input logic              out_valid,
   input logic [ADDR_W-1:0] out_abs,
   input logic              out_fault,
   input logic [ADDR_W-1:0] out_tec,
   input logic              out_wr_inv,
   input logic              out_mode_err
);
   import lap_pkg::*;

   logic low_req;
   assign low_req = (req_addr[ADDR_W-1:PAGE_BITS] < (ADDR_W-PAGE_BITS)'(NUM_WINDOWS)) &&
                    (req_addr[PAGE_BITS-1:0] < PAGE_BITS'(LAP_BYTES));

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);

   a_r5_store_flag: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (out_tec[TEC_WR_BIT] == ($past(req_acc) == ACC_STORE)));

   a_r2_window_store: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_acc == ACC_STORE && lap_enable && !dat_enable && low_req)
      |=> (out_fault && out_tec[TEC_LAP_BIT] && out_abs == '0));

   a_r4_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_mode_err) |-> (!out_fault && !out_wr_inv));

   a_r9_exec_only_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault && out_tec[TEC_LAP_BIT] && out_tec[TEC_DAT_BIT])
      |-> ($past(req_acc) == ACC_FETCH));

   a_r7_abs_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault) |-> (out_abs == '0));

endmodule

bind lap_prefix_unit lap_prefix_unit_chk #(
   .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LAP_BYTES(LAP_BYTES),
   .NUM_WINDOWS(NUM_WINDOWS), .CODE_W(CODE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .req_acc(req_acc), .lap_enable(lap_enable), .dat_enable(dat_enable),
   .out_valid(out_valid), .out_abs(out_abs), .out_fault(out_fault),
   .out_tec(out_tec), .out_wr_inv(out_wr_inv), .out_mode_err(out_mode_err)
);

// File: tb/tb_lap_prefix_unit.sv
module tb_lap_prefix_unit;
   localparam int AW = 16;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          r_valid = 1'b0;
   logic [AW-1:0] r_addr = '0;
   logic [1:0]    r_acc = '0;
   logic [1:0]    r_asc = '0;
   logic          lap_en = 1'b0;
   logic          dat_en = 1'b0;
   logic [2:0]    priv = '0;
   logic          w_fault = 1'b0;
   logic [CW-1:0] w_code = '0;
   logic          w_wok = 1'b1;
   logic          w_xok = 1'b1;
   logic [AW-1:0] w_real = '0;
   logic [AW-1:0] pfx = '0;

   logic          out_valid;
   logic [AW-1:0] out_abs;
   logic          out_fault;
   logic [CW-1:0] out_code;
   logic [AW-1:0] out_tec;
   logic          out_wr_inv;
   logic          out_mode_err;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lap_prefix_unit #(
      .ADDR_W(AW), .PAGE_BITS(12), .LAP_BYTES(512), .NUM_WINDOWS(2),
      .CODE_W(CW), .PROT_CODE(4), .PREFIX_SPAN(32'h2000), .PREFIX_EN(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(r_valid), .req_addr(r_addr),
      .req_acc(r_acc), .req_asc(r_asc), .lap_enable(lap_en), .dat_enable(dat_en),
      .asce_private(priv), .walk_fault(w_fault), .walk_code(w_code),
      .walk_write_ok(w_wok), .walk_exec_ok(w_xok), .walk_real(w_real),
      .prefix(pfx), .out_valid(out_valid), .out_abs(out_abs),
      .out_fault(out_fault), .out_code(out_code), .out_tec(out_tec),
      .out_wr_inv(out_wr_inv), .out_mode_err(out_mode_err)
   );

   // Expected result, packed as {valid, fault, code, tec, wr_inv, mode_err, abs}
   task automatic model(output logic [43:0] e);
      logic [AW-1:0] pg, tec, real_a, absm, ab;
      logic [AW:0]   pend;
      logic          mode, ps, act, pl, bl, f, wi;
      logic [CW-1:0] c;
      pg   = {r_addr[15:12], 12'h000};
      tec  = pg | {14'd0, r_asc} | ((r_acc == 2'd1) ? 16'h0400 : 16'h0800);
      mode = dat_en && (r_asc == 2'd1);
      ps   = (r_asc == 2'd0) ? priv[0] : (r_asc == 2'd2) ? priv[1] :
             (r_asc == 2'd3) ? priv[2] : 1'b0;
      act  = lap_en && !mode && (!dat_en || !ps);
      pl   = r_addr < 16'h2000;
      bl   = (r_addr < 16'd512) || (r_addr >= 16'd4096 && r_addr < 16'd4608);
      real_a = dat_en ? {w_real[15:12], 12'h000} : pg;
      pend = {1'b0, pfx} + 17'h02000;
      if (real_a < 16'h2000) absm = real_a + pfx;
      else if ({1'b0, real_a} >= {1'b0, pfx} && {1'b0, real_a} < pend) absm = real_a - pfx;
      else absm = real_a;
      f = 1'b0; c = '0; wi = act && pl; ab = absm;
      if (mode) begin
         wi = 1'b0; ab = '0;
      end else if (act && bl && r_acc == 2'd1) begin
         f = 1'b1; c = 8'h04; tec = tec | 16'h0080; ab = '0;
      end else if (dat_en && w_fault) begin
         f = 1'b1; c = w_code; ab = '0;
      end else if (dat_en && r_acc == 2'd1 && !w_wok) begin
         f = 1'b1; c = 8'h04; tec = tec | 16'h0004; ab = '0;
      end else if (dat_en && r_acc == 2'd2 && !w_xok) begin
         f = 1'b1; c = 8'h04; tec = tec | 16'h0084; ab = '0;
      end
      e = {1'b1, f, c, tec, wi, mode, ab};
   endtask

   task automatic apply(input string tag);
      logic [43:0] e, a;
      model(e);
      r_valid = 1'b1;
      @(negedge clk);
      r_valid = 1'b0;
      a = {out_valid, out_fault, out_code, out_tec, out_wr_inv, out_mode_err, out_abs};
      vectors++;
      if (a !== e) begin
         miscompares++;
         $display("FAIL %s: actual=%h expected=%h (addr=%h acc=%0d asc=%0d)",
                  tag, a, e, r_addr, r_acc, r_asc);
      end
   endtask

   task automatic idle_check();
      @(negedge clk);
      vectors++;
      if (out_valid !== 1'b0) begin
         miscompares++;
         $display("FAIL R1 idle: actual out_valid=%b expected=0", out_valid);
      end
   endtask

   task automatic defaults();
      lap_en = 0; dat_en = 0; priv = '0; w_fault = 0; w_code = '0;
      w_wok = 1; w_xok = 1; w_real = '0; pfx = '0; r_asc = '0; r_acc = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [15:0] edges [9];
      edges = '{16'd0, 16'd100, 16'd511, 16'd512, 16'd4096,
                16'd4607, 16'd4608, 16'd8191, 16'd8192};
      defaults();
      repeat (3) @(negedge clk);
      // R1: reset state
      vectors++;
      if ({out_valid, out_fault, out_code, out_tec, out_wr_inv, out_mode_err, out_abs} !== 44'd0) begin
         miscompares++;
         $display("FAIL R1 reset: actual=%h expected=0",
                  {out_valid, out_fault, out_code, out_tec, out_wr_inv, out_mode_err, out_abs});
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2: every byte of the two low pages, stores with protection on
      lap_en = 1; r_acc = 2'd1;
      for (int a = 0; a < 16'h4000; a++) begin r_addr = 16'(a); apply("R2"); end
      idle_check();
      // R6: loads over the same span, flag without fault
      r_acc = 2'd0;
      for (int a = 0; a < 16'h4000; a += 3) begin r_addr = 16'(a); apply("R6"); end
      r_acc = 2'd2;
      for (int a = 0; a < 16'h4000; a += 61) begin r_addr = 16'(a); apply("R6"); end

      // R3: activation by enable, translation state, space and private bits
      r_acc = 2'd1;
      for (int le = 0; le < 2; le++)
         for (int de = 0; de < 2; de++)
            for (int s = 0; s < 4; s++) begin
               if (s == 1) continue;
               for (int p = 0; p < 8; p++)
                  foreach (edges[i]) begin
                     lap_en = 1'(le); dat_en = 1'(de); r_asc = 2'(s); priv = 3'(p);
                     r_addr = edges[i]; w_real = edges[i];
                     apply("R3");
                  end
            end

      // R4: access-register space with translation on
      defaults(); dat_en = 1; r_asc = 2'd1; lap_en = 1;
      for (int ac = 0; ac < 3; ac++)
         foreach (edges[i]) begin
            r_acc = 2'(ac); r_addr = edges[i]; w_fault = edges[i][0]; w_wok = 0; w_xok = 0;
            apply("R4");
         end
      // access-register space without translation behaves normally
      dat_en = 0; w_fault = 0; r_acc = 2'd1; r_addr = 16'd20; apply("R3");

      // R5: code word over addresses, accesses and spaces
      defaults();
      for (int a = 0; a < 65536; a += 97)
         for (int ac = 0; ac < 4; ac++)
            for (int s = 0; s < 4; s++) begin
               r_addr = 16'(a); r_acc = 2'(ac); r_asc = 2'(s);
               apply("R5");
            end

      // R7, R8, R9: individual walker-driven faults
      defaults(); dat_en = 1; w_real = 16'h5000; r_addr = 16'h3456;
      w_fault = 1; w_code = 8'h11; r_acc = 2'd0; apply("R7");
      w_code = 8'h3B; r_acc = 2'd2; apply("R7");
      w_fault = 0; w_wok = 0; r_acc = 2'd1; apply("R8");
      w_wok = 1; w_xok = 0; r_acc = 2'd2; apply("R9");
      w_wok = 0; w_xok = 0; r_acc = 2'd0; apply("R10");

      // R10: priority across every combination
      defaults(); dat_en = 1; w_real = 16'h7000;
      for (int le = 0; le < 2; le++)
         for (int ac = 0; ac < 3; ac++)
            for (int wf = 0; wf < 2; wf++)
               for (int wo = 0; wo < 2; wo++)
                  for (int xo = 0; xo < 2; xo++)
                     for (int ai = 0; ai < 3; ai++) begin
                        lap_en = 1'(le); r_acc = 2'(ac); w_fault = 1'(wf);
                        w_wok = 1'(wo); w_xok = 1'(xo); w_code = 8'h10 + 8'(ai);
                        r_addr = (ai == 0) ? 16'h0100 : (ai == 1) ? 16'h1100 : 16'h3000;
                        apply("R10");
                     end

      // R11: prefix swept across its range against every page
      defaults();
      for (int p = 0; p < 65536; p += 256)
         for (int pg = 0; pg < 16; pg++) begin
            pfx = 16'(p); r_addr = {4'(pg), 12'h0A5};
            apply("R11");
         end
      foreach (edges[i])
         for (int pg = 0; pg < 16; pg++) begin
            pfx = edges[i] + 16'h0123; r_addr = {4'(pg), 12'hFFF};
            apply("R11");
         end

      // R12: real address source, walker inputs ignored without translation
      defaults(); pfx = 16'h6000;
      for (int pg = 0; pg < 16; pg++) begin
         dat_en = 1; w_real = {4'(pg), 12'h777}; r_addr = 16'hF123; apply("R12");
         dat_en = 0; w_real = {4'(15 - pg), 12'h000}; w_fault = 1; w_wok = 0; w_xok = 0;
         r_acc = 2'(pg % 3); r_addr = {4'(pg), 12'h321}; apply("R12");
         w_fault = 0; w_wok = 1; w_xok = 1; r_acc = 2'd0;
      end
      idle_check();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule